// File: doc/BRIEF.md
# Multi-Enable Interrupt Pending Aggregator

This block follows a set of interrupt sources and merges them into one level interrupt request for a CPU. Each source has its own level input and its own counter of satisfied enable conditions. A register bank, outside this block, sends one-cycle increment and decrement pulses to that counter. A source is pending only while its input is asserted and its counter is exactly at the enable maximum fixed for that source at elaboration. Below the maximum or above it, the source is not pending.

A running count of pending sources drives the CPU request line. The line is high whenever at least one source is pending. When the CPU asks for a vector, the block returns the code of the lowest-index pending source. The vector code of source i is `VEC_BASE + i*VEC_STEP`. A 4-bit interrupt mask of all ones means the CPU takes no interrupt, so no vector is offered. Every registered effect of an input is visible right after the next rising clock edge.

Top module: `intr_pend_agg`

## Requirements
- R1: Source i is pending exactly when its asserted flag is set and its enable count equals its maximum, `ENA_MAX[i*CNT_W +: CNT_W]`. A count above or below the maximum leaves it not pending.
- R2: A pulse on `en_up[i]` alone raises the count of source i by one, saturating at 2^CNT_W-1. A pulse on `en_down[i]` alone lowers it by one, saturating at 0. Both pulses together, or neither, leave the count unchanged.
- R3: The pending counter always equals the number of pending sources. It rises when a source enters the pending state and falls when one leaves.
- R4: `cpu_irq` is high exactly when the pending counter is nonzero. It is updated at the same clock edge as the pending states.
- R5: The asserted flag of a source changes only on an edge of its level input. Holding the same level has no effect.
- R6: When `cpu_mask` is 4'hF, `vec_valid` is 0 and `vec_code` is 0.
- R7: Otherwise, when any source is pending, `vec_valid` is 1 and `vec_code` is `VEC_BASE + i*VEC_STEP` for the lowest pending index i.
- R8: With no source pending, `vec_valid` is 0 and `vec_code` is 0.
- R9: A synchronous active-low reset clears every asserted flag, enable count and pending state, the pending counter and `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | N_SRC | Level input of each source |
| en_up | input | N_SRC | Enable-count increment pulse for each source |
| en_down | input | N_SRC | Enable-count decrement pulse for each source |
| cpu_mask | input | 4 | CPU interrupt mask; 4'hF blocks the vector |
| cpu_irq | output | 1 | Level interrupt request to the CPU |
| vec_valid | output | 1 | A vector is offered on vec_code |
| vec_code | output | VEC_W | Vector code of the selected source |

## Verification
Some rules are checked by assertions on every cycle:
- The pending counter matches the number of pending bits.
- The request line follows the counter.
- Each enable count steps or holds as its pulses dictate.
- A pending source sits at its maximum with its level previously high.
- The mask and empty cases never offer a vector.

Other behaviour can only be shown by the bench's scenarios:
- The exact equality test (a count that overshoots the maximum stops pending, then pends again after one decrement).
- Saturation at both ends.
- Lowest-index selection when two sources pend.
- The loss of all enable counts across a reset.

// File: rtl/intr_agg_pkg.sv
// Package: shared constants for the interrupt pending aggregator.
// Assumes a 4-bit CPU mask where all ones blocks every interrupt.
package intr_agg_pkg;
    localparam int unsigned MASK_W = 4;
    localparam logic [MASK_W-1:0] MASK_BLOCK_ALL = 4'hF;
endpackage

// File: rtl/intr_src_slot.sv
// Module: one interrupt source. Holds its asserted flag, its saturating
// enable count and its registered pending state. Reports entry to and exit
// from the pending state as combinational strobes for the shared counter.
// Assumes increment and decrement arrive as single-cycle pulses.
module intr_src_slot #(
    parameter int unsigned CNT_W = 2,
    parameter logic [CNT_W-1:0] MAX_CNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             up,
    input  logic             down,
    output logic             pend_q,
    output logic             enter,
    output logic             leave,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic             asserted_q;
    logic             asserted_d;
    logic [CNT_W-1:0] cnt_d;
    logic             pend_d;

    // Next asserted flag: only an edge of the level input changes it.
    always_comb begin
        asserted_d = asserted_q;
        if (level && !asserted_q)
            asserted_d = 1'b1;
        else if (!level && asserted_q)
            asserted_d = 1'b0;
    end

    // Next enable count: single steps with saturation, opposing pulses cancel.
    always_comb begin
        cnt_d = cnt_q;
        if (up && !down && cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
        else if (down && !up && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    // Pending recomputed from the post-update state, with transition strobes.
    always_comb begin
        pend_d = asserted_d && (cnt_d == MAX_CNT);
        enter  = pend_d && !pend_q;
        leave  = !pend_d && pend_q;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asserted_q <= 1'b0;
            cnt_q      <= '0;
            pend_q     <= 1'b0;
        end else begin
            asserted_q <= asserted_d;
            cnt_q      <= cnt_d;
            pend_q     <= pend_d;
        end
    end
endmodule

// File: rtl/intr_pend_counter.sv
// Module: running count of pending sources and the CPU request line.
// Adds the number of entering sources and subtracts the number leaving
// every cycle. Assumes a source never enters and leaves in the same cycle.
module intr_pend_counter #(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned PCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  enter,
    input  logic [N_SRC-1:0]  leave,
    output logic [PCNT_W-1:0] pcount,
    output logic              irq
);
    logic [PCNT_W-1:0] n_enter;
    logic [PCNT_W-1:0] n_leave;
    logic [PCNT_W-1:0] pcount_d;

    // Population counts of the transition strobes.
    always_comb begin
        n_enter = '0;
        n_leave = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            n_enter = n_enter + PCNT_W'(enter[i]);
            n_leave = n_leave + PCNT_W'(leave[i]);
        end
        pcount_d = pcount + n_enter - n_leave;
    end

    // Counter and request line, both taken from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcount <= '0;
            irq    <= 1'b0;
        end else begin
            pcount <= pcount_d;
            irq    <= (pcount_d != '0);
        end
    end
endmodule

// File: rtl/intr_vec_select.sv
// Module: picks the lowest-index pending source and forms its vector code.
// Purely combinational. Assumes the vector code is base plus index times step.
module intr_vec_select
    import intr_agg_pkg::*;
#(
    parameter int unsigned N_SRC    = 8,
    parameter int unsigned VEC_W    = 12,
    parameter logic [VEC_W-1:0] VEC_BASE = '0,
    parameter logic [VEC_W-1:0] VEC_STEP = '0
) (
    input  logic [N_SRC-1:0]  pend,
    input  logic [MASK_W-1:0] cpu_mask,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_code
);
    logic [VEC_W-1:0] pick;
    logic             any;

    // Scan from the top down so the lowest pending index is kept last.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick = VEC_BASE + VEC_W'(i) * VEC_STEP;
                any  = 1'b1;
            end
        end
    end

    // Qualify by the mask and by presence of any pending source.
    always_comb begin
        vec_valid = any && (cpu_mask != MASK_BLOCK_ALL);
        vec_code  = vec_valid ? pick : '0;
    end
endmodule

// File: rtl/intr_pend_agg.sv
// Module: top of the multi-enable interrupt pending aggregator.
// One slot per source, a shared pending counter driving the CPU line,
// and a lowest-index vector selector. Enable maxima are packed CNT_W-bit
// fields, source i at [i*CNT_W +: CNT_W].
module intr_pend_agg
    import intr_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned CNT_W = 2,
    parameter int unsigned VEC_W = 12,
    parameter logic [N_SRC*CNT_W-1:0] ENA_MAX =
        {2'd1, 2'd2, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
    parameter logic [VEC_W-1:0] VEC_BASE = 12'h400,
    parameter logic [VEC_W-1:0] VEC_STEP = 12'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_level,
    input  logic [N_SRC-1:0]  en_up,
    input  logic [N_SRC-1:0]  en_down,
    input  logic [MASK_W-1:0] cpu_mask,
    output logic              cpu_irq,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_code
);
    localparam int unsigned PCNT_W = $clog2(N_SRC + 1);

    logic [N_SRC-1:0]       pend_vec;
    logic [N_SRC-1:0]       enter_vec;
    logic [N_SRC-1:0]       leave_vec;
    logic [N_SRC*CNT_W-1:0] en_cnt_all;
    logic [PCNT_W-1:0]      pend_cnt;

    // One slot per source, each with its own elaborated maximum.
    for (genvar g = 0; g < N_SRC; g++) begin : g_slot
        intr_src_slot #(
            .CNT_W  (CNT_W),
            .MAX_CNT(ENA_MAX[g*CNT_W +: CNT_W])
        ) i_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .level (src_level[g]),
            .up    (en_up[g]),
            .down  (en_down[g]),
            .pend_q(pend_vec[g]),
            .enter (enter_vec[g]),
            .leave (leave_vec[g]),
            .cnt_q (en_cnt_all[g*CNT_W +: CNT_W])
        );
    end

    intr_pend_counter #(
        .N_SRC (N_SRC),
        .PCNT_W(PCNT_W)
    ) i_pcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (enter_vec),
        .leave (leave_vec),
        .pcount(pend_cnt),
        .irq   (cpu_irq)
    );

    intr_vec_select #(
        .N_SRC   (N_SRC),
        .VEC_W   (VEC_W),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) i_vsel (
        .pend     (pend_vec),
        .cpu_mask (cpu_mask),
        .vec_valid(vec_valid),
        .vec_code (vec_code)
    );
endmodule

// File: rtl/intr_pend_agg_chk.sv
// Module: assertion checker bound into the aggregator top.
// Observes ports plus the pending bits, pending counter and enable counts.
module intr_pend_agg_chk
    import intr_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned CNT_W = 2,
    parameter int unsigned VEC_W = 12,
    parameter logic [N_SRC*CNT_W-1:0] ENA_MAX = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_SRC-1:0]           src_level,
    input logic [N_SRC-1:0]           en_up,
    input logic [N_SRC-1:0]           en_down,
    input logic [MASK_W-1:0]          cpu_mask,
    input logic                       cpu_irq,
    input logic                       vec_valid,
    input logic [VEC_W-1:0]           vec_code,
    input logic [N_SRC-1:0]           pend,
    input logic [$clog2(N_SRC+1)-1:0] pcount,
    input logic [N_SRC*CNT_W-1:0]     cnt_all
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R3: the counter tracks the number of pending sources.
    p_count_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pcount) == $countones(pend));

    // R4: the request line follows the counter.
    p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (pcount != '0));

    // R6: an all-ones mask offers no vector.
    p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask == MASK_BLOCK_ALL) |-> (!vec_valid && vec_code == '0));

    // R8: nothing pending offers no vector.
    p_empty_no_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!vec_valid && vec_code == '0));

    // R9: the first cycle after reset starts empty.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pcount == '0 && !cpu_irq));

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        // R2: a lone increment below the top steps the count up by one.
        p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (en_up[g] && !en_down[g] && cnt_all[g*CNT_W +: CNT_W] != CNT_TOP)
            |=> cnt_all[g*CNT_W +: CNT_W] ==
                CNT_W'($past(cnt_all[g*CNT_W +: CNT_W]) + 1'b1));

        // R2: equal pulses leave the count unchanged.
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (en_up[g] == en_down[g]) |=> $stable(cnt_all[g*CNT_W +: CNT_W]));

        // R1: a pending source sits at its maximum.
        p_pend_at_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] |-> (cnt_all[g*CNT_W +: CNT_W] == ENA_MAX[g*CNT_W +: CNT_W]));

        // R5: a pending source saw its level high at the previous edge.
        p_pend_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] |-> $past(src_level[g]));
    end
endmodule

bind intr_pend_agg intr_pend_agg_chk #(
    .N_SRC  (N_SRC),
    .CNT_W  (CNT_W),
    .VEC_W  (VEC_W),
    .ENA_MAX(ENA_MAX)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_level(src_level),
    .en_up    (en_up),
    .en_down  (en_down),
    .cpu_mask (cpu_mask),
    .cpu_irq  (cpu_irq),
    .vec_valid(vec_valid),
    .vec_code (vec_code),
    .pend     (pend_vec),
    .pcount   (pend_cnt),
    .cnt_all  (en_cnt_all)
);

// File: tb/test_intr_pend_agg.sv
// Bench: walks a vector table one clock per row, then directed reset checks.
// Defaults: maxima src0=1 src1=2 src2=3 src3=0 src7=1; vector = 0x400 + 0x20*i.
module test_intr_pend_agg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  src_level;
    logic [7:0]  en_up;
    logic [7:0]  en_down;
    logic [3:0]  cpu_mask;
    logic        cpu_irq;
    logic        vec_valid;
    logic [11:0] vec_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    intr_pend_agg i_intr_pend_agg (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_level(src_level),
        .en_up    (en_up),
        .en_down  (en_down),
        .cpu_mask (cpu_mask),
        .cpu_irq  (cpu_irq),
        .vec_valid(vec_valid),
        .vec_code (vec_code)
    );

    typedef struct packed {
        logic [7:0]  lvl;
        logic [7:0]  up;
        logic [7:0]  dn;
        logic [3:0]  mask;
        logic        e_irq;
        logic        e_val;
        logic [11:0] e_vec;
        logic [7:0]  req;
    } row_t;

    localparam int NROWS = 21;
    localparam row_t TABLE [NROWS] = '{
        '{8'h08, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 12'h460, 8'd7}, // R7 src3 max0
        '{8'h08, 8'h00, 8'h00, 4'hF, 1'b1, 1'b0, 12'h000, 8'd6}, // R6 mask blocks
        '{8'h09, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 12'h460, 8'd1}, // R1 src0 below max
        '{8'h09, 8'h01, 8'h00, 4'h0, 1'b1, 1'b1, 12'h400, 8'd7}, // R7 lowest wins
        '{8'h01, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 12'h400, 8'd3}, // R3 one leaves
        '{8'h01, 8'h01, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000, 8'd1}, // R1 over max
        '{8'h01, 8'h00, 8'h01, 4'h0, 1'b1, 1'b1, 12'h400, 8'd2}, // R2 step down
        '{8'h01, 8'h01, 8'h01, 4'h0, 1'b1, 1'b1, 12'h400, 8'd2}, // R2 both cancel
        '{8'h00, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000, 8'd8}, // R8 empty
        '{8'h00, 8'h00, 8'h01, 4'h0, 1'b0, 1'b0, 12'h000, 8'd4}, // R4 line low
        '{8'h00, 8'h00, 8'h01, 4'h0, 1'b0, 1'b0, 12'h000, 8'd2}, // R2 floor
        '{8'h00, 8'h01, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000, 8'd1}, // R1 no level
        '{8'h01, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 12'h400, 8'd2}, // R2 floor held
        '{8'h81, 8'h80, 8'h00, 4'h0, 1'b1, 1'b1, 12'h400, 8'd3}, // R3 two pending
        '{8'h80, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 12'h4E0, 8'd7}, // R7 src7
        '{8'h80, 8'h00, 8'h80, 4'h0, 1'b0, 1'b0, 12'h000, 8'd4}, // R4 drops
        '{8'h04, 8'h04, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000, 8'd1}, // R1 src2 at 1
        '{8'h04, 8'h04, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000, 8'd5}, // R5 level held
        '{8'h04, 8'h04, 8'h00, 4'h0, 1'b1, 1'b1, 12'h440, 8'd1}, // R1 src2 at 3
        '{8'h04, 8'h04, 8'h00, 4'h5, 1'b1, 1'b1, 12'h440, 8'd2}, // R2 ceiling
        '{8'h00, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000, 8'd5}  // R5 level drop
    };

    task automatic check3(input logic e_irq, input logic e_val,
                          input logic [11:0] e_vec, input int req);
        n_checks++;
        if (cpu_irq !== e_irq || vec_valid !== e_val || vec_code !== e_vec) begin
            n_fails++;
            $display("FAIL R%0d: irq/valid/vec = %b/%b/%h expected %b/%b/%h",
                     req, cpu_irq, vec_valid, vec_code, e_irq, e_val, e_vec);
        end
    endtask

    task automatic drive(input logic [7:0] l, input logic [7:0] u,
                         input logic [7:0] d, input logic [3:0] m);
        @(negedge clk);
        src_level = l;
        en_up     = u;
        en_down   = d;
        cpu_mask  = m;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        src_level = '0; en_up = '0; en_down = '0; cpu_mask = '0;
        repeat (3) @(posedge clk);
        #2;
        check3(1'b0, 1'b0, 12'h000, 9); // R9 reset state
        @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < NROWS; r++) begin
            drive(TABLE[r].lvl, TABLE[r].up, TABLE[r].dn, TABLE[r].mask);
            check3(TABLE[r].e_irq, TABLE[r].e_val, TABLE[r].e_vec, int'(TABLE[r].req));
        end

        // R9: src0 left at count 1, src2 at 3; reset must clear both.
        drive(8'h08, 8'h00, 8'h00, 4'h0);
        check3(1'b1, 1'b1, 12'h460, 9);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check3(1'b0, 1'b0, 12'h000, 9); // R9 cleared under reset
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'h05, 8'h00, 8'h00, 4'h0);
        check3(1'b0, 1'b0, 12'h000, 9); // R9 counts back to zero
        drive(8'h05, 8'h01, 8'h00, 4'h0);
        check3(1'b1, 1'b1, 12'h400, 1); // R1 one step reaches max again
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end
endmodule